// File: doc/BRIEF.md
# Fixed-Length Sync-Hunting Frame Receiver

This block receives a serial bit stream, one bit per cycle in which a bit-valid strobe is high. While hunting it matches every new bit position against a programmable 32-bit sync word. A sync word sits at bit 25 to bit 56 of a sync frame. When the block finds one, it consumes the remaining 584 bits of that frame without output. From then on it cuts the stream into back-to-back 640-bit frames by counting alone.

Every counted frame goes out whole as 80 bytes, CRC included, on a byte interface that marks the first and the last byte. The CRC is checked over the whole frame. A one-cycle frame-done pulse reports a CRC-error flag and an overrun flag, and a 16-bit counter records frames whose CRC failed. Reception continues after a bad frame. A hunt command aborts the current frame and restarts the sync search. If a frame begins while no buffer is available, the frame is dropped, a busy event is raised and reception halts.

Top module: `sync_frame_rx`

## Requirements
- R1: After reset, and each time `enable` goes from low to high, the receiver is hunting: it compares every valid bit position against `sync_word`, first received bit in bit 31. While `enable` is low, no input bit has any effect on the outputs.
- R2: Once the sync word is matched, the next 584 valid bits are consumed without any byte, frame-done or CRC activity.
- R3: After that, each group of 640 valid bits is one frame of 80 bytes with no gap bits between frames. The first received bit of a byte is its bit 7. `out_sof` marks byte 0 and `out_eof` marks byte 79. Each byte is presented one cycle after the edge that samples its eighth bit.
- R4: The CRC register is set to all ones at frame start and shifts MSB-first with polynomial 0x04C11DB7 over all 640 bits. The frame passes when the final register equals `crc_residue`, which is 0 when the last 32 bits are the register value after the first 608. `frame_done` pulses for one cycle after the edge that samples the last bit, and `fd_crc_err` then gives the result.
- R5: A frame with a failed CRC is still delivered byte for byte. `crc_err_count` rises by one, and the next frame is received without a new sync search.
- R6: `hunt_cmd` during a frame aborts it with a `frame_done` pulse whose two flags are clear. It resets the CRC state and returns the block to hunting; the next frame after re-sync is checked from a fresh CRC.
- R7: If `buf_avail` is low when a frame would start, no byte of it is output. `busy_evt` pulses once, and reception stays halted, even across a sync word, until `hunt_cmd`.
- R8: If a byte completes while the previous one is still held (`out_valid` high, `out_ready` low), the new byte overwrites it. The frame closes with `frame_done` and `fd_overrun` set, and the block hunts again if `buf_avail` is high.
- R9: Cycles with `bit_valid` low neither count nor shift bits, so a frame with gaps is delivered exactly as a continuous one.
- R10: In reset, `out_valid`, `frame_done`, `busy_evt` and `crc_err_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Receiver enable; low holds it idle |
| hunt_cmd | input | 1 | Abort current frame and restart sync search |
| buf_avail | input | 1 | A receive buffer is free for the next frame |
| bit_in | input | 1 | Serial data bit |
| bit_valid | input | 1 | `bit_in` carries a bit this cycle |
| sync_word | input | 32 | Sync pattern, first bit in bit 31 |
| crc_residue | input | 32 | CRC register value meaning a good frame |
| out_ready | input | 1 | Consumer takes the held byte |
| out_valid | output | 1 | A byte is held on `out_data` |
| out_data | output | 8 | Received byte |
| out_sof | output | 1 | Held byte is byte 0 of a frame |
| out_eof | output | 1 | Held byte is the last byte of a frame |
| frame_done | output | 1 | One-cycle frame close pulse |
| fd_crc_err | output | 1 | With `frame_done`: CRC failed |
| fd_overrun | output | 1 | With `frame_done`: byte overrun |
| busy_evt | output | 1 | One-cycle pulse: frame dropped for lack of buffer |
| crc_err_count | output | 16 | Count of frames with a failed CRC |

## Verification
Every result comes one register stage after the edge that samples the bit causing it. A byte is presented, and `frame_done` or `busy_evt` pulses, in the cycle after the edge that samples the eighth bit, the last frame bit or the last sync-frame bit. The counter steps at that same edge. Inputs are driven just after a rising edge and outputs are sampled on the falling edge, so each check sees the cycle in which its result is due. A monitor logs every accepted byte and every pulse against snapshots taken before each scenario. The frame-done timing is checked on both falling edges around the last bit, and the held-byte value after an overrun is read straight from the port.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HUNT  = 3'd1,
    ST_SKIP  = 3'd2,
    ST_FRAME = 3'd3,
    ST_HALT  = 3'd4
  } rx_state_e;

  localparam logic [31:0] CRC32_POLY = 32'h04C1_1DB7;
endpackage

// File: rtl/sfr_sync_det.sv
module sfr_sync_det #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         shift_en,
  input  logic         bit_in,
  input  logic [W-1:0] pattern,
  output logic         hit
);
  logic [W-1:0] win_q;
  logic [W-1:0] win_d;

  assign win_d = {win_q[W-2:0], bit_in};
  assign hit   = shift_en && (win_d == pattern);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       win_q <= '0;
    else if (shift_en) win_q <= win_d;
  end
endmodule

// File: rtl/sfr_crc_serial.sv
module sfr_crc_serial #(
  parameter int          W    = 32,
  parameter logic [W-1:0] POLY = sfr_pkg::CRC32_POLY
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         init,
  input  logic         shift,
  input  logic         bit_in,
  output logic [W-1:0] crc_step
);
  logic [W-1:0] crc_q;
  logic [W-1:0] crc_d;
  logic         fb;

  assign fb       = crc_q[W-1] ^ bit_in;
  assign crc_step = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);

  always_comb begin
    crc_d = crc_q;
    if (init)       crc_d = '1;
    else if (shift) crc_d = crc_step;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) crc_q <= '1;
    else         crc_q <= crc_d;
  end
endmodule

// File: rtl/sfr_byte_pack.sv
module sfr_byte_pack (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       shift_en,
  input  logic       bit_in,
  input  logic       byte_last,
  input  logic       mark_sof,
  input  logic       mark_eof,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof,
  output logic       overrun
);
  logic [6:0] acc_q, acc_d;
  logic       vld_d;
  logic [7:0] dat_d;
  logic       sof_d, eof_d;
  logic       byte_done;

  assign byte_done = shift_en && byte_last;
  assign overrun   = byte_done && out_valid && !out_ready;

  always_comb begin
    acc_d = acc_q;
    vld_d = out_valid;
    dat_d = out_data;
    sof_d = out_sof;
    eof_d = out_eof;
    if (shift_en) acc_d = {acc_q[5:0], bit_in};
    if (byte_done) begin
      vld_d = 1'b1;
      dat_d = {acc_q, bit_in};
      sof_d = mark_sof;
      eof_d = mark_eof;
    end else if (out_valid && out_ready) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
    end else begin
      acc_q     <= acc_d;
      out_valid <= vld_d;
      out_data  <= dat_d;
      out_sof   <= sof_d;
      out_eof   <= eof_d;
    end
  end

  // R8
  ovr_keeps_byte_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    overrun |=> out_valid);

  // R8
  held_byte_stays_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && !out_ready && !byte_done) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/sync_frame_rx.sv
module sync_frame_rx #(
  parameter int SYNC_W     = 32,
  parameter int CRC_W      = 32,
  parameter int FRAME_BITS = 640,
  parameter int SYNC_END   = 56,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              hunt_cmd,
  input  logic              buf_avail,
  input  logic              bit_in,
  input  logic              bit_valid,
  input  logic [SYNC_W-1:0] sync_word,
  input  logic [CRC_W-1:0]  crc_residue,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic              frame_done,
  output logic              fd_crc_err,
  output logic              fd_overrun,
  output logic              busy_evt,
  output logic [CNT_W-1:0]  crc_err_count
);
  import sfr_pkg::*;

  localparam int SKIP_BITS   = FRAME_BITS - SYNC_END;
  localparam int FRAME_BYTES = FRAME_BITS / 8;
  localparam int BIT_CW      = $clog2(FRAME_BITS);
  localparam int BYTE_CW     = BIT_CW - 3;
  localparam logic [BIT_CW-1:0]  SKIP_LAST  = BIT_CW'(SKIP_BITS - 1);
  localparam logic [BIT_CW-1:0]  FRAME_LAST = BIT_CW'(FRAME_BITS - 1);
  localparam logic [BYTE_CW-1:0] BYTE_LAST  = BYTE_CW'(FRAME_BYTES - 1);
  localparam logic [BIT_CW-1:0]  BIT_ONE    = {{(BIT_CW-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0]   CNT_ONE    = {{(CNT_W-1){1'b0}}, 1'b1};

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ni   <= rst_meta;
    end
  end

  rx_state_e         state_q, state_d;
  logic [BIT_CW-1:0] bit_cnt_q, bit_cnt_d;
  logic              crc_init, frame_shift;
  logic              done_d, cerr_d, ovr_d, busy_d, cnt_inc;
  logic              sync_hit, pk_overrun;
  logic [CRC_W-1:0]  crc_step;
  logic              crc_fail, last_bit;

  assign frame_shift = (state_q == ST_FRAME) && bit_valid && enable && !hunt_cmd;
  assign last_bit    = (bit_cnt_q == FRAME_LAST);
  assign crc_fail    = (crc_step != crc_residue);

  sfr_sync_det #(.W(SYNC_W)) u_sync (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .shift_en (bit_valid),
    .bit_in   (bit_in),
    .pattern  (sync_word),
    .hit      (sync_hit)
  );

  sfr_crc_serial #(.W(CRC_W), .POLY(CRC_W'(CRC32_POLY))) u_crc (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .init     (crc_init),
    .shift    (frame_shift),
    .bit_in   (bit_in),
    .crc_step (crc_step)
  );

  sfr_byte_pack u_pack (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .shift_en  (frame_shift),
    .bit_in    (bit_in),
    .byte_last (bit_cnt_q[2:0] == 3'd7),
    .mark_sof  (bit_cnt_q[BIT_CW-1:3] == '0),
    .mark_eof  (bit_cnt_q[BIT_CW-1:3] == BYTE_LAST),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .overrun   (pk_overrun)
  );

  always_comb begin
    state_d   = state_q;
    bit_cnt_d = bit_cnt_q;
    crc_init  = 1'b0;
    done_d    = 1'b0;
    cerr_d    = 1'b0;
    ovr_d     = 1'b0;
    busy_d    = 1'b0;
    cnt_inc   = 1'b0;
    if (!enable) begin
      state_d   = ST_IDLE;
      bit_cnt_d = '0;
    end else if (hunt_cmd) begin
      state_d   = ST_HUNT;
      bit_cnt_d = '0;
      crc_init  = 1'b1;
      done_d    = (state_q == ST_FRAME);
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = ST_HUNT;
        ST_HUNT: begin
          if (sync_hit) begin
            state_d   = ST_SKIP;
            bit_cnt_d = '0;
          end
        end
        ST_SKIP: begin
          if (bit_valid) begin
            if (bit_cnt_q == SKIP_LAST) begin
              bit_cnt_d = '0;
              if (buf_avail) begin
                state_d  = ST_FRAME;
                crc_init = 1'b1;
              end else begin
                state_d = ST_HALT;
                busy_d  = 1'b1;
              end
            end else begin
              bit_cnt_d = bit_cnt_q + BIT_ONE;
            end
          end
        end
        ST_FRAME: begin
          if (pk_overrun) begin
            done_d    = 1'b1;
            ovr_d     = 1'b1;
            bit_cnt_d = '0;
            state_d   = buf_avail ? ST_HUNT : ST_HALT;
          end else if (bit_valid) begin
            if (last_bit) begin
              done_d    = 1'b1;
              cerr_d    = crc_fail;
              cnt_inc   = crc_fail;
              bit_cnt_d = '0;
              if (buf_avail) begin
                crc_init = 1'b1;
              end else begin
                state_d = ST_HALT;
                busy_d  = 1'b1;
              end
            end else begin
              bit_cnt_d = bit_cnt_q + BIT_ONE;
            end
          end
        end
        ST_HALT: state_d = ST_HALT;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      bit_cnt_q     <= '0;
      frame_done    <= 1'b0;
      fd_crc_err    <= 1'b0;
      fd_overrun    <= 1'b0;
      busy_evt      <= 1'b0;
      crc_err_count <= '0;
    end else begin
      state_q    <= state_d;
      bit_cnt_q  <= bit_cnt_d;
      frame_done <= done_d;
      fd_crc_err <= cerr_d;
      fd_overrun <= ovr_d;
      busy_evt   <= busy_d;
      if (cnt_inc) crc_err_count <= crc_err_count + CNT_ONE;
    end
  end

  // R1
  hunt_to_skip_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_HUNT && sync_hit && enable && !hunt_cmd) |=> (state_q == ST_SKIP));

  // R3
  frame_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_FRAME) |-> (bit_cnt_q <= FRAME_LAST));

  // R4
  flag_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (fd_crc_err || fd_overrun) |-> frame_done);

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (crc_err_count != $past(crc_err_count)) |-> (frame_done && fd_crc_err));

  // R7
  busy_halts_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_evt |-> (state_q == ST_HALT));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_IDLE) |=> !frame_done && !busy_evt);
endmodule

// File: tb/sync_frame_rx_tb.sv
module sync_frame_rx_tb;
  localparam logic [31:0] SYNC = 32'hB4E1_2F53;
  localparam logic [31:0] POLY = 32'h04C1_1DB7;

  logic        clk = 1'b0;
  logic        rst_n, enable, hunt_cmd, buf_avail, bit_in, bit_valid, out_ready;
  logic        out_valid, out_sof, out_eof, frame_done, fd_crc_err, fd_overrun, busy_evt;
  logic [7:0]  out_data;
  logic [15:0] crc_err_count;

  int check_n = 0;
  int fail_n  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  sync_frame_rx u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .hunt_cmd(hunt_cmd),
    .buf_avail(buf_avail), .bit_in(bit_in), .bit_valid(bit_valid),
    .sync_word(SYNC), .crc_residue(32'h0), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof), .frame_done(frame_done), .fd_crc_err(fd_crc_err),
    .fd_overrun(fd_overrun), .busy_evt(busy_evt), .crc_err_count(crc_err_count)
  );

  // monitor
  logic [7:0] got [0:2047];
  logic       gsof [0:2047];
  logic       geof [0:2047];
  logic       fdc [0:127];
  logic       fdo [0:127];
  int got_n = 0, fd_n = 0, busy_n = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready && got_n < 2048) begin
        got[got_n] = out_data; gsof[got_n] = out_sof; geof[got_n] = out_eof;
        got_n++;
      end
      if (frame_done && fd_n < 128) begin
        fdc[fd_n] = fd_crc_err; fdo[fd_n] = fd_overrun; fd_n++;
      end
      if (busy_evt) busy_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    check_n++;
    if (!ok) begin
      fail_n++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [639:0] make_frame(input logic [31:0] seed, input bit corrupt);
    logic [31:0]  s = seed;
    logic [31:0]  c = '1;
    logic [639:0] f = '0;
    logic         fb;
    for (int i = 0; i < 608; i++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      f[639-i] = s[0];
    end
    for (int i = 0; i < 608; i++) begin
      fb = c[31] ^ f[639-i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    f[31:0] = c;
    if (corrupt) f[300] = ~f[300];
    return f;
  endfunction

  task automatic send_bit(input logic b);
    @(posedge clk); #1;
    bit_in = b; bit_valid = 1'b1;
  endtask

  task automatic pause(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      bit_valid = 1'b0;
    end
  endtask

  task automatic send_sync_frame();
    for (int i = 0; i < 24; i++) send_bit(1'b0);
    for (int i = 31; i >= 0; i--) send_bit(SYNC[i]);
    for (int i = 0; i < 584; i++) send_bit(1'b0);
  endtask

  task automatic send_frame(input logic [639:0] f, input bit gaps);
    for (int i = 0; i < 640; i++) begin
      send_bit(f[639-i]);
      if (gaps && (i % 3 == 0)) pause(1);
    end
  endtask

  task automatic pulse_hunt();
    @(posedge clk); #1;
    hunt_cmd = 1'b1; bit_valid = 1'b0;
    @(posedge clk); #1;
    hunt_cmd = 1'b0;
    pause(2);
  endtask

  task automatic check_frame(input int base, input logic [639:0] f, input string req);
    int bad = 0;
    for (int k = 0; k < 80; k++) begin
      if (got[base+k] !== f[639-8*k -: 8]) bad++;
      if (gsof[base+k] !== (k == 0)) bad++;
      if (geof[base+k] !== (k == 79)) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset();
    // R10
    chk(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
    chk(frame_done == 1'b0 && busy_evt == 1'b0, "R10 pulses", {frame_done, busy_evt}, 0);
    chk(crc_err_count == 16'd0, "R10 counter", crc_err_count, 0);
  endtask

  task automatic t_basic();
    logic [639:0] fa, fb;
    int g0, f0;
    fa = make_frame(32'h1234_5678, 1'b0);
    fb = make_frame(32'h0BAD_F00D, 1'b0);
    g0 = got_n; f0 = fd_n;
    send_sync_frame();
    send_frame(fa, 1'b0);
    send_frame(fb, 1'b0);
    // R4 pulse due one cycle after the edge sampling the last bit
    @(negedge clk);
    chk(frame_done == 1'b0, "R4 done early", frame_done, 0);
    @(posedge clk); #1; bit_valid = 1'b0;
    @(negedge clk);
    chk(frame_done == 1'b1 && fd_crc_err == 1'b0, "R4 done on time", {frame_done, fd_crc_err}, 2);
    pause(4);
    // R2 nothing from the sync frame, R3 exact byte count
    chk(got_n - g0 == 160, "R2 R3 byte count", got_n - g0, 160);
    check_frame(g0, fa, "R3 frame A bytes");
    check_frame(g0 + 80, fb, "R3 frame B bytes");
    chk(fd_n - f0 == 2 && fdc[f0] == 0 && fdc[f0+1] == 0, "R4 good CRC flags", fd_n - f0, 2);
    chk(crc_err_count == 16'd0, "R4 counter idle", crc_err_count, 0);
  endtask

  task automatic t_crc();
    logic [639:0] fa, fb;
    int g0, f0;
    logic [15:0] c0;
    fa = make_frame(32'hCAFE_0001, 1'b1);
    fb = make_frame(32'hCAFE_0002, 1'b0);
    pulse_hunt();
    g0 = got_n; f0 = fd_n; c0 = crc_err_count;
    send_sync_frame();
    send_frame(fa, 1'b0);
    send_frame(fb, 1'b0);
    pause(4);
    check_frame(g0, fa, "R5 bad frame still delivered");
    chk(fd_n - f0 == 2 && fdc[f0] == 1 && fdo[f0] == 0, "R5 crc flag", fdc[f0], 1);
    chk(fdc[f0+1] == 0, "R5 next frame clean", fdc[f0+1], 0);
    chk(crc_err_count == c0 + 16'd1, "R5 counter step", crc_err_count, c0 + 16'd1);
    check_frame(g0 + 80, fb, "R5 no re-hunt");
  endtask

  task automatic t_abort();
    logic [639:0] fa, fc;
    int g0, f0;
    fa = make_frame(32'h5555_AAAA, 1'b0);
    fc = make_frame(32'h7777_1111, 1'b0);
    pulse_hunt();
    g0 = got_n;
    send_sync_frame();
    for (int i = 0; i < 200; i++) send_bit(fa[639-i]);
    f0 = fd_n;
    pulse_hunt();
    // R6
    chk(fd_n - f0 == 1 && fdc[f0] == 0 && fdo[f0] == 0, "R6 abort close", fd_n - f0, 1);
    chk(got_n - g0 == 25, "R6 bytes before abort", got_n - g0, 25);
    g0 = got_n; f0 = fd_n;
    send_sync_frame();
    send_frame(fc, 1'b0);
    pause(4);
    check_frame(g0, fc, "R6 after re-sync");
    chk(fd_n - f0 == 1 && fdc[f0] == 0, "R6 CRC restarted", fdc[f0], 0);
  endtask

  task automatic t_busy();
    logic [639:0] fa;
    int g0, f0, b0;
    fa = make_frame(32'h0F0F_3C3C, 1'b0);
    pulse_hunt();
    g0 = got_n; f0 = fd_n; b0 = busy_n;
    buf_avail = 1'b0;
    send_sync_frame();
    pause(3);
    // R7
    chk(busy_n - b0 == 1, "R7 busy pulse", busy_n - b0, 1);
    buf_avail = 1'b1;
    send_frame(fa, 1'b0);
    send_sync_frame();
    send_frame(fa, 1'b0);
    pause(4);
    chk(got_n == g0 && fd_n == f0, "R7 halted no output", got_n - g0, 0);
    pulse_hunt();
    g0 = got_n;
    send_sync_frame();
    send_frame(fa, 1'b0);
    pause(4);
    check_frame(g0, fa, "R7 resumes after hunt");
  endtask

  task automatic t_overrun();
    logic [639:0] fa, fb;
    int g0, f0;
    logic [15:0] c0;
    fa = make_frame(32'h2468_ACE0, 1'b0);
    fb = make_frame(32'h1357_9BDF, 1'b0);
    pulse_hunt();
    out_ready = 1'b0;
    f0 = fd_n; c0 = crc_err_count;
    send_sync_frame();
    for (int i = 0; i < 16; i++) send_bit(fa[639-i]);
    pause(3);
    // R8
    chk(fd_n - f0 == 1 && fdo[f0] == 1 && fdc[f0] == 0, "R8 overrun flag", fdo[f0], 1);
    chk(out_valid == 1'b1 && out_data == fa[631:624], "R8 byte overwritten", out_data, fa[631:624]);
    chk(crc_err_count == c0, "R8 counter untouched", crc_err_count, c0);
    out_ready = 1'b1;
    pause(2);
    g0 = got_n;
    send_sync_frame();
    send_frame(fb, 1'b0);
    pause(4);
    check_frame(g0, fb, "R8 hunting again");
  endtask

  task automatic t_enable();
    logic [639:0] fa;
    int g0, f0;
    fa = make_frame(32'h9999_0001, 1'b0);
    enable = 1'b0;
    pause(2);
    g0 = got_n; f0 = fd_n;
    send_sync_frame();
    send_frame(fa, 1'b0);
    pause(4);
    // R1
    chk(got_n == g0 && fd_n == f0, "R1 disabled ignores", got_n - g0, 0);
    enable = 1'b1;
    pause(2);
    send_sync_frame();
    send_frame(fa, 1'b0);
    pause(4);
    check_frame(g0, fa, "R1 hunts after enable");
  endtask

  task automatic t_gaps();
    logic [639:0] fa;
    int g0;
    fa = make_frame(32'h4242_4242, 1'b0);
    pulse_hunt();
    g0 = got_n;
    send_sync_frame();
    send_frame(fa, 1'b1);
    pause(4);
    // R9
    check_frame(g0, fa, "R9 gapped frame");
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b1; hunt_cmd = 1'b0; buf_avail = 1'b1;
    bit_in = 1'b0; bit_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    #1 rst_n = 1'b1;
    pause(4);
    t_basic();
    t_crc();
    t_abort();
    t_busy();
    t_overrun();
    t_enable();
    t_gaps();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", fail_n, check_n);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check_n++;
      fail_n++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", fail_n, check_n);
      $finish;
    end
  end
endmodule